// File: doc/BRIEF.md
# ECC Correction Applier

This block sits beside a BCH-style decoder and repairs a 512-byte sector that is held in its own internal RAM. After the sector has been streamed through the decoder, a controller pulses `start`. The block waits until the decoder is idle. It then takes the error count, the packed byte locations and the packed error patterns. Each reported byte is fixed by reading it, XORing the pattern into it and writing it back. The syndrome arithmetic is outside this block. The only inputs it needs are the decoder's results, laid out the way a decoder presents them in 32-bit words.

A sector with more errors than the code can correct is flagged as failed, and its data is left alone. A location that points past the last data byte lands in the parity area, so it is skipped. At the end of a run the block raises `done` for one cycle. The number of fixes it applied and the fail flag are given with that pulse. A byte-wide host port fills the buffer before a run and drains it afterwards.

Top module: `ecc_fix_applier`

## Requirements
- R1: After reset, `done`, `fail` and `busy` are 0 and `fix_count` is 0.
- R2: While `busy` is 0, a host write stores `buf_wdata` at `buf_addr`. The byte at the address sampled on a clock edge appears on `buf_rdata` after that edge. While `busy` is 1, host writes are ignored.
- R3: After `start`, nothing is captured and no byte is written while `dec_busy` is 1. The run continues on the first edge at which `dec_busy` is 0.
- R4: The error count is `err_cnt` (5 bits). A count from 0 to 8 applies exactly that many entries, indices 0 to count-1. Higher-indexed entries are ignored.
- R5: A count above 8 sets `fail`, gives `fix_count` 0 and leaves every buffer byte unchanged.
- R6: Location n is taken from 32-bit word n/2 of `loc_words` (word w at bits [32w+31:32w]). It uses word bits [9:0] when n is even and [25:16] when n is odd. All other word bits are ignored.
- R7: Pattern n is byte n mod 4 of 32-bit word n/4 of `pat_words`, counting from the least-significant byte. The pattern is XORed into the byte at location n.
- R8: Fixes are applied one at a time from index count-1 down to 0, each as a full read-modify-write. Two entries with the same location therefore both take effect (XOR of both patterns).
- R9: A location of 512 or more is skipped. It writes nothing and is not counted in `fix_count`.
- R10: `done` is a one-cycle pulse. `fix_count` and `fail` are valid with it and are held until the next `start`. The edge count from the edge that samples `start` (edge 0) to the edge after which `done` is high is B+2+2F+S. Here B is the number of edges that saw `dec_busy` high, F is the number of applied fixes and S is the number of skipped entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a correction run (accepted when idle) |
| dec_busy | input | 1 | Decoder busy flag (bit 31 of the decoder status) |
| err_cnt | input | 5 | Error count (low 5 bits of the sector status) |
| loc_words | input | 128 | Four packed location words |
| pat_words | input | 64 | Two packed pattern words |
| buf_we | input | 1 | Host write enable |
| buf_addr | input | 9 | Host byte address |
| buf_wdata | input | 8 | Host write data |
| buf_rdata | output | 8 | Host read data, one edge after the address |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sector was uncorrectable |
| fix_count | output | 4 | Number of bytes corrected |

## Verification
A host read is due one edge after its address is driven, so the bench drives on falling edges and samples on the next falling edge. For each run, the bench counts rising edges from the edge that takes `start` up to the falling edge at which `done` is first seen. It compares that count with B+2+2F+S, using B, F and S worked out from its own list of entries. `fail`, `fix_count` and the whole 512-byte buffer are then compared against a shadow copy. `fix_count` and `fail` are checked again a few cycles later to show they are held.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_EVAL,
    ST_RD,
    ST_WR,
    ST_DONE
  } fix_state_t;
endpackage

// File: rtl/ecc_sector_ram.sv
module ecc_sector_ram #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // single port, registered read, read returns the old value on a write
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/ecc_fix_unpack.sv
module ecc_fix_unpack #(
  parameter int MAX_ERR = 8,
  parameter int WORD_W  = 32,
  parameter int LOC_W   = 10,
  parameter int DATA_W  = 8,
  localparam int HALF_W    = WORD_W / 2,
  localparam int LOC_WORDS = MAX_ERR / 2,
  localparam int PAT_PER_W = WORD_W / DATA_W,
  localparam int PAT_WORDS = MAX_ERR / PAT_PER_W,
  localparam int IDX_W     = $clog2(MAX_ERR)
) (
  input  logic [LOC_WORDS*WORD_W-1:0] loc_words,
  input  logic [PAT_WORDS*WORD_W-1:0] pat_words,
  input  logic [IDX_W-1:0]            idx,
  output logic [LOC_W-1:0]            loc,
  output logic [DATA_W-1:0]           pat
);
  logic [LOC_W-1:0]  loc_arr [MAX_ERR];
  logic [DATA_W-1:0] pat_arr [MAX_ERR];
  logic [2*LOC_WORDS-1:0] unused_gap;

  // entry n: location in half n%2 of word n/2, pattern in byte n%4 of word n/4
  for (genvar n = 0; n < MAX_ERR; n++) begin : g_entry
    assign loc_arr[n] = loc_words[(n/2)*WORD_W + (n%2)*HALF_W +: LOC_W];
    assign pat_arr[n] = pat_words[(n/PAT_PER_W)*WORD_W + (n%PAT_PER_W)*DATA_W +: DATA_W];
  end

  // upper bits of each half-word carry no location information
  for (genvar h = 0; h < 2*LOC_WORDS; h++) begin : g_gap
    assign unused_gap[h] = ^loc_words[h*HALF_W + LOC_W +: HALF_W - LOC_W];
  end

  assign loc = loc_arr[idx];
  assign pat = pat_arr[idx];
endmodule

// File: rtl/ecc_fix_ctrl.sv
module ecc_fix_ctrl
  import ecc_fix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int MAX_ERR      = 8,
  parameter int WORD_W       = 32,
  parameter int LOC_W        = 10,
  parameter int DATA_W       = 8,
  parameter int CNT_W        = 5,
  localparam int ADDR_W    = $clog2(SECTOR_BYTES),
  localparam int LOC_WORDS = MAX_ERR / 2,
  localparam int PAT_WORDS = MAX_ERR * DATA_W / WORD_W,
  localparam int IDX_W     = $clog2(MAX_ERR),
  localparam int FIXC_W    = $clog2(MAX_ERR + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        dec_busy,
  input  logic [CNT_W-1:0]            err_cnt,
  input  logic [LOC_WORDS*WORD_W-1:0] loc_words,
  input  logic [PAT_WORDS*WORD_W-1:0] pat_words,
  input  logic [DATA_W-1:0]           ram_rdata,
  output logic                        eng_we,
  output logic [ADDR_W-1:0]           eng_addr,
  output logic [DATA_W-1:0]           eng_wdata,
  output logic                        busy,
  output logic                        in_wait,
  output logic                        done,
  output logic                        fail,
  output logic [FIXC_W-1:0]           fix_count
);
  fix_state_t state_q, state_d;
  logic [IDX_W-1:0]            idx_q, idx_d;
  logic                        fail_q, fail_d;
  logic [FIXC_W-1:0]           fixc_q, fixc_d;
  logic                        cap_en;
  logic [CNT_W-1:0]            cnt_q;
  logic [LOC_WORDS*WORD_W-1:0] loc_q;
  logic [PAT_WORDS*WORD_W-1:0] pat_q;
  logic [LOC_W-1:0]            loc_cur;
  logic [DATA_W-1:0]           pat_cur;
  logic                        loc_oob;

  ecc_fix_unpack #(
    .MAX_ERR(MAX_ERR), .WORD_W(WORD_W), .LOC_W(LOC_W), .DATA_W(DATA_W)
  ) u_unpack (
    .loc_words(loc_q),
    .pat_words(pat_q),
    .idx      (idx_q),
    .loc      (loc_cur),
    .pat      (pat_cur)
  );

  assign loc_oob = (loc_cur >= LOC_W'(SECTOR_BYTES));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    fail_d  = fail_q;
    fixc_d  = fixc_q;
    cap_en  = 1'b0;
    eng_we  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_WAIT;
          fail_d  = 1'b0;
          fixc_d  = '0;
        end
      end
      ST_WAIT: begin
        if (!dec_busy) begin
          cap_en  = 1'b1;
          state_d = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (cnt_q > CNT_W'(MAX_ERR)) begin
          fail_d  = 1'b1;
          state_d = ST_DONE;
        end else if (cnt_q == '0) begin
          state_d = ST_DONE;
        end else begin
          idx_d   = IDX_W'(cnt_q - CNT_W'(1));
          state_d = ST_RD;
        end
      end
      ST_RD: begin
        if (loc_oob) begin
          if (idx_q == '0) state_d = ST_DONE;
          else             idx_d   = idx_q - IDX_W'(1);
        end else begin
          state_d = ST_WR;
        end
      end
      ST_WR: begin
        eng_we = 1'b1;
        fixc_d = fixc_q + FIXC_W'(1);
        if (idx_q == '0) begin
          state_d = ST_DONE;
        end else begin
          idx_d   = idx_q - IDX_W'(1);
          state_d = ST_RD;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      fail_q  <= 1'b0;
      fixc_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      fail_q  <= fail_d;
      fixc_q  <= fixc_d;
    end
  end

  // decoder results, taken once the decoder reports idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      loc_q <= '0;
      pat_q <= '0;
    end else if (cap_en) begin
      cnt_q <= err_cnt;
      loc_q <= loc_words;
      pat_q <= pat_words;
    end
  end

  assign eng_addr  = loc_cur[ADDR_W-1:0];
  assign eng_wdata = ram_rdata ^ pat_cur;
  assign busy      = (state_q != ST_IDLE);
  assign in_wait   = (state_q == ST_WAIT);
  assign done      = (state_q == ST_DONE);
  assign fail      = fail_q;
  assign fix_count = fixc_q;
endmodule

// File: rtl/ecc_fix_applier.sv
module ecc_fix_applier #(
  parameter int SECTOR_BYTES = 512,
  parameter int MAX_ERR      = 8,
  parameter int WORD_W       = 32,
  parameter int LOC_W        = 10,
  parameter int DATA_W       = 8,
  parameter int CNT_W        = 5,
  localparam int ADDR_W    = $clog2(SECTOR_BYTES),
  localparam int LOC_WORDS = MAX_ERR / 2,
  localparam int PAT_WORDS = MAX_ERR * DATA_W / WORD_W,
  localparam int FIXC_W    = $clog2(MAX_ERR + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        dec_busy,
  input  logic [CNT_W-1:0]            err_cnt,
  input  logic [LOC_WORDS*WORD_W-1:0] loc_words,
  input  logic [PAT_WORDS*WORD_W-1:0] pat_words,
  input  logic                        buf_we,
  input  logic [ADDR_W-1:0]           buf_addr,
  input  logic [DATA_W-1:0]           buf_wdata,
  output logic [DATA_W-1:0]           buf_rdata,
  output logic                        busy,
  output logic                        done,
  output logic                        fail,
  output logic [FIXC_W-1:0]           fix_count
);
  logic              rst_meta, rst_n_s;
  logic              eng_we, in_wait;
  logic [ADDR_W-1:0] eng_addr, ram_addr;
  logic [DATA_W-1:0] eng_wdata, ram_wdata;
  logic              ram_we;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  ecc_fix_ctrl #(
    .SECTOR_BYTES(SECTOR_BYTES), .MAX_ERR(MAX_ERR), .WORD_W(WORD_W),
    .LOC_W(LOC_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start    (start),
    .dec_busy (dec_busy),
    .err_cnt  (err_cnt),
    .loc_words(loc_words),
    .pat_words(pat_words),
    .ram_rdata(buf_rdata),
    .eng_we   (eng_we),
    .eng_addr (eng_addr),
    .eng_wdata(eng_wdata),
    .busy     (busy),
    .in_wait  (in_wait),
    .done     (done),
    .fail     (fail),
    .fix_count(fix_count)
  );

  // engine owns the buffer for the whole run
  assign ram_we    = busy ? eng_we    : buf_we;
  assign ram_addr  = busy ? eng_addr  : buf_addr;
  assign ram_wdata = busy ? eng_wdata : buf_wdata;

  ecc_sector_ram #(.DEPTH(SECTOR_BYTES), .DATA_W(DATA_W)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .addr (ram_addr),
    .wdata(ram_wdata),
    .rdata(buf_rdata)
  );
endmodule

// File: rtl/ecc_fix_checker.sv
module ecc_fix_checker #(
  parameter int MAX_ERR = 8,
  parameter int FIXC_W  = 4
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              start,
  input logic              dec_busy,
  input logic              busy,
  input logic              in_wait,
  input logic              done,
  input logic              fail,
  input logic [FIXC_W-1:0] fix_count,
  input logic              buf_we,
  input logic              eng_we,
  input logic              ram_we
);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done);

  assert_results_held_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy && !start) |=> ($stable(fix_count) && $stable(fail)));

  assert_fail_no_fix_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && fail) |-> (fix_count == '0));

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> (fix_count <= FIXC_W'(MAX_ERR)));

  assert_wait_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_wait && dec_busy) |=> (in_wait && !eng_we));

  assert_host_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && buf_we) |-> (ram_we == eng_we));
endmodule

bind ecc_fix_applier ecc_fix_checker #(.MAX_ERR(MAX_ERR), .FIXC_W(FIXC_W)) u_chk (
  .clk      (clk),
  .rst_n_s  (rst_n_s),
  .start    (start),
  .dec_busy (dec_busy),
  .busy     (busy),
  .in_wait  (in_wait),
  .done     (done),
  .fail     (fail),
  .fix_count(fix_count),
  .buf_we   (buf_we),
  .eng_we   (eng_we),
  .ram_we   (ram_we)
);

// File: tb/tb_ecc_fix_applier.sv
module tb_ecc_fix_applier;
  localparam int CLK_PERIOD = 10;
  localparam int NBYTES = 512;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start, dec_busy, buf_we;
  logic [4:0]   err_cnt;
  logic [127:0] loc_words;
  logic [63:0]  pat_words;
  logic [8:0]   buf_addr;
  logic [7:0]   buf_wdata, buf_rdata;
  logic         busy, done, fail;
  logic [3:0]   fix_count;

  int total = 0;
  int bad = 0;
  logic [7:0] shadow [NBYTES];
  int tl [8];
  int tp [8];

  ecc_fix_applier dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dec_busy(dec_busy),
    .err_cnt(err_cnt), .loc_words(loc_words), .pat_words(pat_words),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .busy(busy), .done(done), .fail(fail),
    .fix_count(fix_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic host_write(input int a, input int d);
    buf_addr = 9'(a); buf_wdata = 8'(d); buf_we = 1'b1;
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic host_read(input int a, output int d);
    buf_addr = 9'(a);
    @(negedge clk);
    d = int'(buf_rdata);
  endtask

  task automatic verify_buf(input string req);
    int first_a = -1, first_v = 0, miss = 0;
    for (int a = 0; a < NBYTES; a++) begin
      int v;
      host_read(a, v);
      if (v != int'(shadow[a])) begin
        if (first_a < 0) begin first_a = a; first_v = v; end
        miss++;
      end
    end
    if (first_a < 0) check(req, 0, 0);
    else check({req, " buffer byte"}, first_v, int'(shadow[first_a]));
  endtask

  // one correction run: cnt entries from tl/tp, bcyc edges of decoder busy
  task automatic run_fix(input int cnt, input int bcyc, input bit poke, input string req);
    int f = 0, s = 0, n = 0, exp_fail;
    loc_words = '1;
    pat_words = '0;
    for (int k = 0; k < 8; k++) begin
      loc_words[(k/2)*32 + (k%2)*16 +: 10] = 10'(tl[k]);
      pat_words[(k/4)*32 + (k%4)*8 +: 8]   = 8'(tp[k]);
    end
    exp_fail = (cnt > 8) ? 1 : 0;
    if (exp_fail == 0)
      for (int k = cnt - 1; k >= 0; k--) begin
        if (tl[k] >= NBYTES) s++;
        else begin f++; shadow[tl[k]] = shadow[tl[k]] ^ 8'(tp[k]); end
      end
    err_cnt  = 5'(cnt);
    dec_busy = (bcyc > 0);
    start    = 1'b1;
    @(posedge clk);
    forever begin
      @(negedge clk);
      start = 1'b0;
      buf_we = 1'b0;
      if (done || n > 500) break;
      if (poke && n == 1) begin
        buf_addr = 9'd5; buf_wdata = ~shadow[5]; buf_we = 1'b1;
      end
      if (bcyc > 0 && n == bcyc) begin
        check("R3 busy while decoder busy", int'(busy), 1);
        check("R3 no done while decoder busy", int'(done), 0);
      end
      if (n >= bcyc) dec_busy = 1'b0;
      @(posedge clk);
      n++;
    end
    check({req, " R10 done edge"}, n, bcyc + 2 + 2*f + s);
    check({req, " R5 fail flag"}, int'(fail), exp_fail);
    check({req, " R4 fix count"}, int'(fix_count), f);
    repeat (3) @(negedge clk);
    check("R10 done is a pulse", int'(done), 0);
    check("R10 count held", int'(fix_count), f);
    check("R10 fail held", int'(fail), exp_fail);
    verify_buf(req);
  endtask

  task automatic t_reset;
    check("R1 done", int'(done), 0);
    check("R1 fail", int'(fail), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 fix_count", int'(fix_count), 0);
  endtask

  task automatic t_fill;
    for (int a = 0; a < NBYTES; a++) begin
      shadow[a] = 8'(a * 37 + 11);
      host_write(a, int'(shadow[a]));
    end
    verify_buf("R2 fill and read back");
  endtask

  task automatic t_zero;
    for (int k = 0; k < 8; k++) begin tl[k] = 30 + k; tp[k] = 8'hFF; end
    run_fix(0, 0, 1'b0, "R4 zero errors");
  endtask

  task automatic t_full8;
    tl = '{3, 100, 511, 0, 257, 64, 400, 200};
    tp = '{8'h01, 8'h80, 8'hFF, 8'h5A, 8'hA5, 8'h3C, 8'hC3, 8'h7E};
    run_fix(8, 0, 1'b0, "R6 R7 eight fixes");
  endtask

  task automatic t_partial;
    tl = '{12, 13, 14, 40, 41, 42, 43, 44};
    tp = '{8'h11, 8'h22, 8'h44, 8'h99, 8'h99, 8'h99, 8'h99, 8'h99};
    run_fix(3, 0, 1'b0, "R4 three of eight");
  endtask

  task automatic t_over;
    for (int k = 0; k < 8; k++) begin tl[k] = 60 + k; tp[k] = 8'h0F; end
    run_fix(9, 0, 1'b0, "R5 count nine");
    run_fix(31, 0, 1'b0, "R5 count max");
  endtask

  task automatic t_skip;
    tl = '{600, 20, 1023, 21, 0, 0, 0, 0};
    tp = '{8'hAA, 8'h55, 8'hAA, 8'h33, 0, 0, 0, 0};
    run_fix(4, 0, 1'b0, "R9 parity locations");
  endtask

  task automatic t_dup;
    tl = '{50, 50, 0, 0, 0, 0, 0, 0};
    tp = '{8'h0F, 8'hF0, 0, 0, 0, 0, 0, 0};
    run_fix(2, 0, 1'b0, "R8 repeated location");
  endtask

  task automatic t_wait;
    tl = '{77, 0, 0, 0, 0, 0, 0, 0};
    tp = '{8'h81, 0, 0, 0, 0, 0, 0, 0};
    run_fix(1, 6, 1'b1, "R3 R2 decoder busy and host blocked");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; dec_busy = 1'b0; buf_we = 1'b0;
    err_cnt = '0; loc_words = '0; pat_words = '0; buf_addr = '0; buf_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fill();
    t_zero();
    t_full8();
    t_partial();
    t_over();
    t_skip();
    t_dup();
    t_wait();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule